// File: doc/BRIEF.md
# Seven-Channel DMA Launch and Completion Register Block

This block is the register front end of a multi-channel DMA controller. Every channel owns three 32-bit registers: a memory address, a block-control word and a channel-control word. Bit 24 of the channel-control word is the channel's busy/start bit. Two global registers sit beside them. The first holds one enable bit per channel. The second holds 24 plain read/write bits and a byte of completion flags that are cleared by writing 1.

The block does not move data. It decides when a channel may start and sends a one-cycle start pulse to an external transfer engine. It then waits for that engine's per-channel done pulse. On that pulse it drops the busy bit, records a completion flag when the channel's interrupt enable is set, and sends a single-cycle request toward the interrupt controller.

When more than one channel becomes ready in the same cycle, the start pulses go out one per cycle, lowest channel number first.

Top module: `dmac_regs`

## Requirements
- R1: After reset every register reads 0, and both `start_o` and `irq_o` are 0.
- R2: Channel n (0..6) decodes its registers at byte address 0x80+0x10·n: the address register at +0, block control at +4 and channel control at +8. The enable register is at 0xF0 and the interrupt register at 0xF4. A write to any of these reads back unchanged, except where R6 and R8 say otherwise. Any other address reads 0.
- R3: A channel-control write to an idle channel launches it when written bit 24 is 1 and enable-register bit 4·n+3 is already 1. In that case `start_o[n]` is high for exactly the one cycle that follows the write.
- R4: If bit 4·n+3 of the enable register is 0, a channel-control write with bit 24 set produces no start pulse. Bit 24 then reads back as 1.
- R5: A write to the enable register launches every channel that meets three conditions: its bit 24 is set, it has not been launched, and its enable bit is written as 1. The start pulses follow that write one per cycle, lowest channel first, and `start_o` is never more than one-hot.
- R6: A `done_i[n]` pulse on a launched channel clears its channel-control bit 24 from the next cycle on.
- R7: On completion of channel n, if interrupt-register bit 16+n is 1, flag bit 24+n is set and `irq_o` is high for exactly the next cycle. If bit 16+n is 0, no flag is set and no pulse is sent.
- R8: A write to the interrupt register replaces bits 0–23 with the written data. It clears each flag in bits 24–31 whose written bit is 1 and keeps each flag whose written bit is 0.
- R9: A `done_i[n]` pulse on a channel that has not been launched has no effect: no flag is set, no pulse appears on `irq_o`, and bit 24 keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte address for both read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| done_i | input | 7 | Per-channel transfer-finished pulses |
| start_o | output | 7 | Per-channel one-cycle launch pulses (one-hot or zero) |
| irq_o | output | 1 | One-cycle completion request to the interrupt controller |

## Verification
Read data is combinational, so the bench samples `rdata` 1 ns after it sets `addr`, away from any clock edge. A start pulse is due in the cycle right after the edge that takes the launching write. The bench checks it at the falling edge that ends the write, then checks that it has dropped one falling edge later. When several channels launch together, the bench checks each successive falling edge for the next channel in order. The effects of a done pulse on the busy bit, the flag and `irq_o` all appear at the edge that samples the pulse. The bench therefore checks `irq_o` at the falling edge that ends the pulse and again one cycle later, and it reads the registers only after that edge.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
   localparam int DW        = 32;
   localparam int BUSY_BIT  = 24;
   localparam int IEN_LSB   = 16;
   localparam int FLAG_LSB  = 24;
   localparam int LOW_W     = 24;
   localparam int CH_BASE   = 'h80;
   localparam int CH_STRIDE = 'h10;
   localparam int OFS_ADR   = 0;
   localparam int OFS_BLK   = 4;
   localparam int OFS_CTL   = 8;
   localparam int EN_ADDR   = 'hF0;
   localparam int IRQ_ADDR  = 'hF4;
   localparam int EN_STRIDE = 4;
   localparam int EN_POS    = 3;

   function automatic int en_bit_of(input int ch);
      return EN_STRIDE * ch + EN_POS;
   endfunction
endpackage

// File: rtl/dmac_chan.sv
module dmac_chan
   import dmac_pkg::*;
#(
   parameter int CH = 0,
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic          en_cur,
   input  logic          en_wr,
   input  logic          en_new,
   input  logic          grant,
   input  logic          done,
   output logic          pend,
   output logic          cmpl,
   output logic          hit,
   output logic [DW-1:0] rd
);
   localparam logic [AW-1:0] A_ADR = AW'(CH_BASE + CH * CH_STRIDE + OFS_ADR);
   localparam logic [AW-1:0] A_BLK = AW'(CH_BASE + CH * CH_STRIDE + OFS_BLK);
   localparam logic [AW-1:0] A_CTL = AW'(CH_BASE + CH * CH_STRIDE + OFS_CTL);

   logic [DW-1:0] adr_q, blk_q, ctl_q;
   logic          act_q;
   logic          wr_ctl, launch;

   assign wr_ctl = wr_en && (addr == A_CTL);
   assign cmpl   = done && act_q;
   assign launch = !pend && !act_q &&
                   ((wr_ctl && wdata[BUSY_BIT] && en_cur) ||
                    (en_wr && en_new && ctl_q[BUSY_BIT]));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         adr_q <= '0;
         blk_q <= '0;
         ctl_q <= '0;
      end else begin
         if (wr_en && addr == A_ADR) adr_q <= wdata;
         if (wr_en && addr == A_BLK) blk_q <= wdata;
         if (wr_ctl) ctl_q <= wdata;
         if (cmpl) ctl_q[BUSY_BIT] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend  <= 1'b0;
         act_q <= 1'b0;
      end else begin
         if (grant) pend <= 1'b0;
         else if (launch) pend <= 1'b1;
         if (grant) act_q <= 1'b1;
         else if (cmpl) act_q <= 1'b0;
      end
   end

   always_comb begin
      hit = 1'b1;
      rd  = '0;
      if (addr == A_ADR) rd = adr_q;
      else if (addr == A_BLK) rd = blk_q;
      else if (addr == A_CTL) rd = ctl_q;
      else hit = 1'b0;
   end

   assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> ctl_q[BUSY_BIT]);
   assert_done_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmpl |=> !ctl_q[BUSY_BIT]);
   assert_stray_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !act_q && !grant && !wr_ctl) |=> $stable(ctl_q));
endmodule

// File: rtl/dmac_pick.sv
module dmac_pick #(
   parameter int N = 7
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);
   logic [N:0] seen;

   assign seen[0] = 1'b0;
   for (genvar i = 0; i < N; i++) begin : g_pick
      assign gnt[i]    = req[i] && !seen[i];
      assign seen[i+1] = seen[i] || req[i];
   end

   always_comb begin
      assert_onehot_R5: assert ($onehot0(gnt));
   end
endmodule

// File: rtl/dmac_irq.sv
module dmac_irq
   import dmac_pkg::*;
#(
   parameter int N = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   input  logic [N-1:0]  cmpl,
   output logic [DW-1:0] icr,
   output logic          irq
);
   localparam int FLAG_W = DW - LOW_W;

   logic [DW-1:0] icr_n;
   logic [N-1:0]  hot;

   assign hot = cmpl & icr[IEN_LSB +: N];

   always_comb begin
      icr_n = icr;
      if (wr) begin
         icr_n[LOW_W-1:0]     = wdata[LOW_W-1:0];
         icr_n[DW-1:FLAG_LSB] = icr[DW-1:FLAG_LSB] & ~wdata[DW-1:FLAG_LSB];
      end
      for (int n = 0; n < N; n++)
         if (hot[n]) icr_n[FLAG_LSB+n] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         icr <= '0;
         irq <= 1'b0;
      end else begin
         icr <= icr_n;
         irq <= |hot;
      end
   end

   assert_irq_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (icr[DW-1:FLAG_LSB] != '0));
   assert_irq_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq || $past(|cmpl));
   assert_low_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> icr[LOW_W-1:0] == $past(wdata[LOW_W-1:0]));
   assert_flag_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && cmpl == '0) |=>
         icr[DW-1:FLAG_LSB] == ($past(icr[DW-1:FLAG_LSB]) & ~$past(wdata[DW-1:FLAG_LSB])));

   if (FLAG_W < N) begin : g_bad_flags
      $error("flag field narrower than channel count");
   end
endmodule

// File: rtl/dmac_regs.sv
module dmac_regs
   import dmac_pkg::*;
#(
   parameter int NUM_CH = 7,
   parameter int AW     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     addr,
   input  logic [DW-1:0]     wdata,
   output logic [DW-1:0]     rdata,
   input  logic [NUM_CH-1:0] done_i,
   output logic [NUM_CH-1:0] start_o,
   output logic              irq_o
);
   localparam logic [AW-1:0] A_EN  = AW'(EN_ADDR);
   localparam logic [AW-1:0] A_IRQ = AW'(IRQ_ADDR);

   if (NUM_CH < 1 || NUM_CH > 7) begin : g_bad_ch
      $error("NUM_CH must be 1..7");
   end
   if (AW < 8) begin : g_bad_aw
      $error("AW must cover the 0x00..0xFF map");
   end

   logic [DW-1:0]     en_q, icr;
   logic              en_wr, irq_wr;
   logic [NUM_CH-1:0] pend, cmpl, hit;
   logic [DW-1:0]     ch_rd [NUM_CH];

   assign en_wr  = wr_en && addr == A_EN;
   assign irq_wr = wr_en && addr == A_IRQ;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= '0;
      else if (en_wr) en_q <= wdata;
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dmac_chan #(.CH(c), .AW(AW)) u_ch (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_en  (wr_en),
         .addr   (addr),
         .wdata  (wdata),
         .en_cur (en_q[en_bit_of(c)]),
         .en_wr  (en_wr),
         .en_new (wdata[en_bit_of(c)]),
         .grant  (start_o[c]),
         .done   (done_i[c]),
         .pend   (pend[c]),
         .cmpl   (cmpl[c]),
         .hit    (hit[c]),
         .rd     (ch_rd[c])
      );
   end

   dmac_pick #(.N(NUM_CH)) u_pick (
      .req (pend),
      .gnt (start_o)
   );

   dmac_irq #(.N(NUM_CH)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (irq_wr),
      .wdata (wdata),
      .cmpl  (cmpl),
      .icr   (icr),
      .irq   (irq_o)
   );

   always_comb begin
      rdata = '0;
      if (addr == A_EN) rdata = en_q;
      else if (addr == A_IRQ) rdata = icr;
      else
         for (int c = 0; c < NUM_CH; c++)
            if (hit[c]) rdata = ch_rd[c];
   end

   assert_en_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !en_wr |=> $stable(en_q));
   assert_start_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (start_o != '0) |-> (en_q != '0 || $past(en_wr)));
endmodule

// File: tb/dmac_regs_test.sv
module dmac_regs_test;
   localparam int CLK_NS = 10;
   localparam int N      = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [7:0]    addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [N-1:0]  done_i = '0;
   logic [N-1:0]  start_o;
   logic          irq_o;

   int checks = 0;
   int failures = 0;

   dmac_regs uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .done_i(done_i), .start_o(start_o), .irq_o(irq_o)
   );

   always #(CLK_NS/2) clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
      addr = a;
      #1;
      chk(req, rdata, exp);
   endtask

   task automatic pulse_done(input logic [N-1:0] m);
      @(negedge clk);
      done_i = m;
      @(negedge clk);
      done_i = '0;
   endtask

   function automatic logic [7:0] ctl_a(input int n);
      return 8'(8'h88 + 16 * n);
   endfunction

   initial begin
      #(CLK_NS * 100000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] low;
      logic [31:0] flg;
      #(CLK_NS * 3);
      @(negedge clk);
      // R1: reset values across the whole map
      chk("R1 start", 32'(start_o), 0);
      chk("R1 irq", 32'(irq_o), 0);
      for (int a = 0; a < 256; a += 4) rd_chk("R1 reg", 8'(a), 0);
      rst_n = 1'b1;

      for (int n = 0; n < N; n++) begin
         logic ien;
         ien = (n % 2 == 0);
         low = ien ? (32'h1 << (16 + n)) : 32'h0;
         // R2: address and block registers
         wr(8'(8'h80 + 16 * n), 32'hA000_0000 + 32'(n) * 32'h111);
         wr(8'(8'h84 + 16 * n), 32'h0005_0000 + 32'(n));
         rd_chk("R2 adr", 8'(8'h80 + 16 * n), 32'hA000_0000 + 32'(n) * 32'h111);
         rd_chk("R2 blk", 8'(8'h84 + 16 * n), 32'h0005_0000 + 32'(n));
         wr(8'hF0, 32'h0);
         wr(8'hF4, low);
         rd_chk("R2 irqreg", 8'hF4, low);
         // R4: disabled channel does not launch
         wr(ctl_a(n), 32'h0100_0000 | 32'(n));
         chk("R4 no start", 32'(start_o), 0);
         rd_chk("R4 busy kept", ctl_a(n), 32'h0100_0000 | 32'(n));
         // R9: done on a channel never launched
         pulse_done(N'(1) << n);
         chk("R9 no irq", 32'(irq_o), 0);
         rd_chk("R9 busy", ctl_a(n), 32'h0100_0000 | 32'(n));
         rd_chk("R9 no flag", 8'hF4, low);
         // R5: enabling launches the waiting channel
         wr(8'hF0, 32'h1 << (4 * n + 3));
         chk("R5 start", 32'(start_o), 32'h1 << n);
         @(negedge clk);
         chk("R5 one cycle", 32'(start_o), 0);
         rd_chk("R2 enreg", 8'hF0, 32'h1 << (4 * n + 3));
         // R6/R7: completion
         pulse_done(N'(1) << n);
         chk("R7 irq", 32'(irq_o), 32'(ien));
         flg = ien ? (32'h1 << (24 + n)) : 32'h0;
         rd_chk("R6 busy clear", ctl_a(n), 32'(n));
         rd_chk("R7 flag", 8'hF4, low | flg);
         @(negedge clk);
         chk("R7 irq width", 32'(irq_o), 0);
         // R3: launch directly by control write
         wr(ctl_a(n), 32'h0100_0030);
         chk("R3 start", 32'(start_o), 32'h1 << n);
         @(negedge clk);
         chk("R3 one cycle", 32'(start_o), 0);
         pulse_done(N'(1) << n);
         chk("R7 irq again", 32'(irq_o), 32'(ien));
         rd_chk("R6 busy clear 2", ctl_a(n), 32'h0000_0030);
         // R8: write-1 clear and low replace
         wr(8'hF4, 32'hFF5A_5A5A);
         rd_chk("R8 clear all", 8'hF4, 32'h005A_5A5A);
      end

      // R8: partial clear keeps unwritten flags
      wr(8'hF0, 32'h0000_0088);
      wr(8'hF4, 32'h0003_0000);
      wr(ctl_a(0), 32'h0100_0000);
      @(negedge clk);
      pulse_done(7'b0000001);
      wr(ctl_a(1), 32'h0100_0000);
      @(negedge clk);
      pulse_done(7'b0000010);
      rd_chk("R8 two flags", 8'hF4, 32'h0303_0000);
      wr(8'hF4, 32'h0203_0000);
      rd_chk("R8 partial clear", 8'hF4, 32'h0103_0000);

      // R5: several channels launched together, lowest first
      wr(8'hF0, 32'h0);
      wr(ctl_a(6), 32'h0100_0000);
      wr(ctl_a(1), 32'h0100_0000);
      wr(ctl_a(4), 32'h0100_0000);
      chk("R4 none yet", 32'(start_o), 0);
      wr(8'hF0, 32'h0888_8888);
      chk("R5 first", 32'(start_o), 32'h02);
      @(negedge clk);
      chk("R5 second", 32'(start_o), 32'h10);
      @(negedge clk);
      chk("R5 third", 32'(start_o), 32'h40);
      @(negedge clk);
      chk("R5 drained", 32'(start_o), 0);

      // R2: unmapped addresses
      rd_chk("R2 hole", 8'h8C, 0);
      rd_chk("R2 low", 8'h00, 0);
      rd_chk("R2 top", 8'hF8, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule